// File: doc/BRIEF.md
# Centre-Bin Subcarrier Placer with DC-First Reordering

This block sits in front of an inverse FFT. It takes a stream of A active frequency-domain complex samples per symbol and turns them into an N-bin frame in the order the transform consumes. The active carriers sit around the centre of the spectrum, and the DC bin is left empty. Every bin that no active carrier occupies is sent as zero. The swap of spectral halves that puts DC at transform index 0 is not a separate pass. The write address applies it directly, so each input sample goes straight to its final bin.

Storage holds two frames. One half fills from the input while the other half streams out. The input is a valid/ready sample stream. The output is one bin per cycle, with a marker on the first bin and a marker on the last bin of each frame. The frame length (512 or 1024 bins) and the active carrier count are taken from configuration inputs once per frame. The block does not map QAM symbols, insert pilots or compute the transform. It only moves samples.

Top module: `sc_mapper`

## Requirements
- R1: A frame is N consecutive output cycles with `out_valid` high. N is 512 when `cfg_long` is 0 and 1024 when it is 1. `out_first` marks output index 0 and `out_last` marks index N−1.
- R2: Output index 0 (the DC bin) is always zero.
- R3: Input sample i with i < A/2 (negative frequencies, just below DC) appears at output index N−A/2+i.
- R4: Input sample i with i ≥ A/2 appears at output index i−A/2+1, just above DC.
- R5: Every other output index is zero. This holds even when the same buffer half carried data at that index in an earlier frame.
- R6: A is `cfg_nact` with bit 0 cleared, so an odd value is rounded down. Supported values are 2 ≤ A ≤ N−2.
- R7: `cfg_long` and `cfg_nact` are sampled when the first sample of a frame is accepted. A change during the frame takes effect on the next frame.
- R8: `in_ready` is low only while both halves hold complete frames that have not been fully read. It rises in the same cycle as `out_last` of the frame being read.
- R9: Frames leave in arrival order. When the next frame is already complete, its `out_first` comes in the cycle right after the previous `out_last`.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_long | input | 1 | Frame length select: 0 gives 512 bins, 1 gives 1024 bins |
| cfg_nact | input | 10 | Active carrier count; bit 0 ignored |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_re | input | 16 | Input sample, real part |
| in_im | input | 16 | Input sample, imaginary part |
| out_valid | output | 1 | Output bin valid |
| out_first | output | 1 | Output bin is index 0 |
| out_last | output | 1 | Output bin is index N−1 |
| out_re | output | 16 | Output bin, real part |
| out_im | output | 16 | Output bin, imaginary part |

## Verification
Two situations are hard to reach from the ports. The first is a full stall. The reader must still be busy with one frame while a second frame completes. The stimulus sends two tiny four-carrier frames back to back into 512-bin frames, so both halves are full long before the first frame drains. It then checks that `in_ready` comes back exactly with `out_last`, and that the next frame follows with no gap.

The second is a half being reused with stale contents. A wide-band frame is followed, two frames later, by a narrow one in the same half. This exposes any guard bin that still carries old data. A configuration change inside a frame and an odd carrier count cover the sampling and rounding rules.

// File: rtl/sc_mapper.sv
module sc_mapper #(
  parameter int DW   = 16,
  parameter int NMAX = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_long,
  input  logic [$clog2(NMAX)-1:0]  cfg_nact,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DW-1:0]            in_re,
  input  logic [DW-1:0]            in_im,
  output logic                     out_valid,
  output logic                     out_first,
  output logic                     out_last,
  output logic [DW-1:0]            out_re,
  output logic [DW-1:0]            out_im
);
  localparam int LA = $clog2(NMAX);
  localparam int LN = LA + 1;

  logic [2*DW-1:0] mem [2*NMAX];
  logic [2*DW-1:0] memq;
  logic [1:0]      full;
  logic            wsel, rsel, w_long, rd_act, z_q;
  logic [LA-1:0]   wcnt, wr_addr, w_a, rd_idx;
  logic            h_long [2];
  logic [LA-1:0]   h_a [2];

  // write side: one address generator does centre placement, DC skip and shift
  logic          fr_start, cur_long, acc, wr_done;
  logic [LA-1:0] cur_a, cur_addr, last_bin, first_addr;
  logic [LN-1:0] cur_n;

  assign fr_start   = (wcnt == '0);
  assign cur_long   = fr_start ? cfg_long : w_long;
  assign cur_a      = fr_start ? (cfg_nact & ~LA'(1)) : w_a;
  assign cur_n      = cur_long ? LN'(NMAX) : LN'(NMAX/2);
  assign last_bin   = LA'(cur_n - LN'(1));
  assign first_addr = LA'(cur_n - LN'(cur_a >> 1));
  assign cur_addr   = fr_start ? first_addr : wr_addr;
  assign in_ready   = !full[wsel];
  assign acc        = in_valid && in_ready;
  assign wr_done    = acc && (wcnt == cur_a - LA'(1));

  always_ff @(posedge clk)
    if (acc) mem[{wsel, cur_addr}] <= {in_re, in_im};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt    <= '0;
      wr_addr <= '0;
      w_a     <= '0;
      w_long  <= 1'b0;
      wsel    <= 1'b0;
      for (int h = 0; h < 2; h++) begin
        h_long[h] <= 1'b0;
        h_a[h]    <= '0;
      end
    end else if (acc) begin
      if (fr_start) begin
        w_long <= cfg_long;
        w_a    <= cur_a;
      end
      wr_addr <= (cur_addr == last_bin) ? LA'(1) : cur_addr + LA'(1);
      if (wr_done) begin
        wcnt         <= '0;
        wsel         <= ~wsel;
        h_long[wsel] <= cur_long;
        h_a[wsel]    <= cur_a;
      end else begin
        wcnt <= wcnt + LA'(1);
      end
    end
  end

  // read side: guards and DC derived from the stored count, no per-bin flags
  logic          r_end, r_zero;
  logic [LA-1:0] r_half, r_last;
  logic [LN-1:0] r_n;

  assign r_n    = h_long[rsel] ? LN'(NMAX) : LN'(NMAX/2);
  assign r_last = LA'(r_n - LN'(1));
  assign r_half = h_a[rsel] >> 1;
  assign r_end  = rd_act && (rd_idx == r_last);
  assign r_zero = (rd_idx == '0) ||
                  ((LN'(rd_idx) > LN'(r_half)) && (LN'(rd_idx) < r_n - LN'(r_half)));

  always_ff @(posedge clk) begin
    if (!rst_n) full <= 2'b00;
    else        full <= (full | (2'({1'b0, wr_done}) << wsel))
                             & ~(2'({1'b0, r_end}) << rsel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act    <= 1'b0;
      rd_idx    <= '0;
      rsel      <= 1'b0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      z_q       <= 1'b1;
    end else begin
      if (!rd_act) begin
        rd_idx <= '0;
        if (full[rsel]) rd_act <= 1'b1;
      end else if (r_end) begin
        rsel   <= ~rsel;
        rd_idx <= '0;
        rd_act <= full[~rsel];
      end else begin
        rd_idx <= rd_idx + LA'(1);
      end
      out_valid <= rd_act;
      out_first <= rd_act && (rd_idx == '0);
      out_last  <= r_end;
      z_q       <= r_zero;
    end
  end

  always_ff @(posedge clk) memq <= mem[{rsel, rd_idx}];

  assign out_re = z_q ? '0 : memq[2*DW-1:DW];
  assign out_im = z_q ? '0 : memq[DW-1:0];
endmodule

// File: rtl/sc_mapper_chk.sv
module sc_mapper_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_first,
  input logic          out_last,
  input logic [DW-1:0] out_re,
  input logic [DW-1:0] out_im
);
  // R1
  first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first || out_last) |-> out_valid);

  // R1
  frame_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R9
  after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_valid || out_first));

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);

  // R2
  dc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_re == '0 && out_im == '0));

  // R8
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_last);
endmodule

bind sc_mapper sc_mapper_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_first(out_first), .out_last(out_last), .out_re(out_re), .out_im(out_im)
);

// File: tb/tb_sc_mapper.sv
module tb_sc_mapper;
  localparam int DW = 16;
  localparam int NMAX = 1024;
  localparam int LA = 10;

  logic clk = 1'b0, rst_n = 1'b0, cfg_long = 1'b0, in_valid = 1'b0;
  logic [LA-1:0] cfg_nact = '0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_first, out_last;
  logic [DW-1:0] out_re, out_im;

  sc_mapper #(.DW(DW), .NMAX(NMAX)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_long(cfg_long), .cfg_nact(cfg_nact),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_re(out_re), .out_im(out_im));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, frame_no = 0;
  bit done = 0;
  logic [31:0] eq_d[$];
  bit eq_f[$], eq_l[$];
  string eq_r[$];

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model: expected frame built from the requirements, compared each cycle
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (eq_d.size() == 0) begin
        chk(0, "R1", "output with no expected frame", 1, 0);
      end else begin
        logic [31:0] d; bit f, l; string r;
        d = eq_d.pop_front(); f = eq_f.pop_front(); l = eq_l.pop_front(); r = eq_r.pop_front();
        checks++;
        if ({out_re, out_im} !== d) begin
          errors++;
          $display("FAIL %s bin data actual %h expected %h", r, {out_re, out_im}, d);
        end
        if (out_first !== f || out_last !== l)
          chk(0, "R1", "first/last markers", {out_first, out_last}, {f, l});
      end
    end
  end

  task automatic send(input bit lng, input int nact_raw, input bit chg);
    int a, n;
    logic [31:0] s[];
    a = nact_raw & ~1;
    n = lng ? 1024 : 512;
    s = new[a];
    frame_no++;
    cfg_long = lng;
    cfg_nact = LA'(nact_raw);
    for (int i = 0; i < a; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      s[i] = {16'(frame_no * 97 + i + 1), 16'(i * 3 + 5)};
      {in_re, in_im} = s[i];
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      if (chg && i == 0) begin #1; cfg_long = ~lng; cfg_nact = 10'd6; end
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] v; string r;
      v = '0; r = "R5";
      if (k == 0) r = "R2";
      if (k >= 1 && k <= a/2) begin v = s[k - 1 + a/2]; r = "R4"; end
      if (k >= n - a/2) begin v = s[k - (n - a/2)]; r = "R3"; end
      eq_d.push_back(v); eq_f.push_back(k == 0); eq_l.push_back(k == n-1); eq_r.push_back(r);
    end
  endtask

  task automatic drain();
    while (eq_d.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired pending %0d expected 0", eq_d.size());
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);

    send(0, 24, 0);    // R3 R4 short frame, half 0
    send(1, 600, 0);   // R1 long frame, half 1
    send(1, 1000, 0);  // wide band, half 0
    send(1, 8, 0);     // R5 narrow frame reusing half 1
    drain();
    send(0, 11, 0);    // R6 odd count rounds to 10
    send(0, 40, 1);    // R7 config changes after first sample
    send(1, 6, 0);     // R7 changed config applies to next frame
    drain();

    // R8 stall: two tiny frames while reader is busy
    send(0, 4, 0);
    send(0, 4, 0);
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R8", "in_ready with both halves full", in_ready, 0);
    while (!out_last) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R8", "in_ready at out_last", in_ready, 1);
    @(negedge clk); #1;
    // R9
    chk(out_valid && out_first, "R9", "back-to-back frame start", {out_valid, out_first}, 3);
    drain();

    chk(eq_d.size() == 0, "R1", "undelivered bins", eq_d.size(), 0);
    chk(out_valid == 1'b0, "R9", "idle after last frame", out_valid, 0);
    report();
  end
endmodule